// File: doc/BRIEF.md
# I2C Transmit Byte Handoff Controller

This block sits between software and the byte shifter of an I2C port that can work as bus master or as addressed slave. Software places a byte in a one-byte holding register. Writing it marks the buffer as occupied. The controller moves the held byte into the shifter only when the acknowledge rules allow it, and those rules differ for master and slave. It records the acknowledge bit returned by the far end. When the far end does not acknowledge, it either asks the master sequencer for a STOP or repeated START, or lets go of SDA while acting as slave. The block also keeps a read-only register for received bytes.

Bit timing, clock stretching and arbitration are outside the block. A neighbouring bit engine reports each finished byte as a single-cycle strobe. That strobe is either an address-phase strobe or a data-byte strobe, and it comes with the sampled ninth bit. Every output is registered and changes on the clock edge that samples the strobe. Clearing the enable input returns every register to its idle value.

Top module: `i2c_txb_handoff`

## Requirements
- R1: While `enable_i` is 0, the following values hold one edge later: `txbe_o` is 1, and `sh_load_o`, `sh_data_o`, `stop_req_o`, `sda_release_o`, `rx_ack_o` and `rx_data_o` are all 0. After reset the outputs take the same values.
- R2: A cycle with `wr_i`=1 stores `wr_data_i` as the pending byte and drives `txbe_o` to 0 from the next edge.
- R3: Master transmit means `is_master_i`=1 and `rw_i`=0. In this mode, an `addr_evt_i` strobe with `ack_i`=0 while a byte is pending gives a one-cycle `sh_load_o` pulse after that edge. `sh_data_o` then carries the byte, and `txbe_o` becomes 1.
- R4: The device transmits when master with `rw_i`=0, or slave with `rw_i`=1. While transmitting, a `byte_done_i` strobe with `ack_i`=0 loads the pending byte into the shifter in the same way as R3.
- R5: A master that sees `ack_i`=1 raises `stop_req_o` for exactly one cycle after the edge, with no load and `txbe_o` left at 0. This applies to an address strobe, and to a data strobe while transmitting.
- R6: A slave transmitter that sees `ack_i`=1 on `byte_done_i` sets `sda_release_o`. The flag holds until the next `addr_evt_i`, and the byte stays pending. A slave `addr_evt_i` with `rw_i`=1 loads the pending byte whatever the value of `ack_i`.
- R7: `rx_ack_o` takes the value of `ack_i` on every master address strobe and on every data strobe while the device transmits. It holds its value at all other times.
- R8: No load happens when no byte is pending, or on a data strobe while the device is the receiver.
- R9: `rx_load_i` copies `rx_byte_i` into `rx_data_o` from the next edge. The register has no write path from software.
- R10: A write in the same cycle as a load sends the old byte to the shifter and leaves the new byte pending, with `txbe_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Module enable; 0 holds everything idle |
| is_master_i | input | 1 | 1 = master, 0 = slave |
| rw_i | input | 1 | Read/write bit of the current transfer (0 = master writes) |
| wr_i | input | 1 | Software write strobe for the holding register |
| wr_data_i | input | 8 | Byte written by software |
| addr_evt_i | input | 1 | Ninth-bit strobe of the address phase (slave: own address matched) |
| byte_done_i | input | 1 | Ninth-bit strobe of a data byte |
| ack_i | input | 1 | Sampled ninth bit, 0 = acknowledge |
| rx_load_i | input | 1 | Strobe that captures a received byte |
| rx_byte_i | input | 8 | Received byte from the shifter |
| sh_load_o | output | 1 | One-cycle pulse: shifter takes `sh_data_o` |
| sh_data_o | output | 8 | Byte handed to the shifter |
| txbe_o | output | 1 | Transmit buffer empty |
| rx_ack_o | output | 1 | Last received acknowledge bit |
| stop_req_o | output | 1 | Request for STOP or repeated START |
| sda_release_o | output | 1 | Slave lets go of SDA |
| rx_data_o | output | 8 | Read-only received byte |

## Verification
Every result is due exactly one edge after the cycle in which its strobe or write is present. The pulses `sh_load_o` and `stop_req_o` last only that one cycle. `sda_release_o` lasts until the next address strobe. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output 3 ns after each rising edge, so each expectation is tested in the cycle it is due. Directed checks sample on the falling edge that follows the strobe cycle, and they also confirm that pulses drop one cycle later.

// File: rtl/i2c_txb_pkg.sv
package i2c_txb_pkg;
  // Decisions taken in one strobe cycle
  typedef struct packed {
    logic load;     // hand pending byte to shifter
    logic stop;     // master asks for STOP / repeated START
    logic rel_set;  // slave lets go of SDA
    logic ack_upd;  // capture the ninth bit
  } hand_evt_t;

  function automatic logic dev_xmit(input logic master, input logic rw);
    return master ? ~rw : rw;
  endfunction
endpackage

// File: rtl/i2c_txb_hold.sv
module i2c_txb_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_i,
  output logic              empty_o,
  output logic [DATA_W-1:0] sh_data_o
);
  logic              empty_q, empty_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  always_comb begin
    empty_d = empty_q;
    hold_d  = hold_q;
    sh_d    = sh_q;
    if (!en_i) begin
      empty_d = 1'b1;
      hold_d  = '0;
      sh_d    = '0;
    end else begin
      if (load_i) begin
        sh_d    = hold_q;
        empty_d = 1'b1;
      end
      if (wr_i) begin
        hold_d  = wdata_i;
        empty_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= 1'b1;
      hold_q  <= '0;
      sh_q    <= '0;
    end else begin
      empty_q <= empty_d;
      hold_q  <= hold_d;
      sh_q    <= sh_d;
    end
  end

  assign empty_o   = empty_q;
  assign sh_data_o = sh_q;

  // R2
  wr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && wr_i) |=> (!empty_o));
  // R3
  load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && load_i && !wr_i) |=> empty_o);
endmodule

// File: rtl/i2c_txb_ctrl.sv
module i2c_txb_ctrl
  import i2c_txb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic is_master_i,
  input  logic rw_i,
  input  logic addr_evt_i,
  input  logic byte_done_i,
  input  logic ack_i,
  input  logic pending_i,
  output logic load_o,
  output logic sh_load_o,
  output logic stop_req_o,
  output logic sda_rel_o,
  output logic rx_ack_o
);
  hand_evt_t evt;
  logic xmit;
  logic sh_load_q, stop_q, rel_q, ack_q;
  logic rel_d, ack_d;

  assign xmit = dev_xmit(is_master_i, rw_i);

  always_comb begin
    evt = '0;
    if (en_i) begin
      if (is_master_i) begin
        evt.load    = pending_i && !ack_i && (addr_evt_i || (byte_done_i && xmit)) && xmit;
        evt.stop    = ack_i && (addr_evt_i || (byte_done_i && xmit));
        evt.ack_upd = addr_evt_i || (byte_done_i && xmit);
      end else begin
        evt.load    = pending_i && xmit && (addr_evt_i || (byte_done_i && !ack_i));
        evt.rel_set = xmit && byte_done_i && ack_i;
        evt.ack_upd = xmit && byte_done_i;
      end
    end
  end

  always_comb begin
    rel_d = rel_q;
    ack_d = ack_q;
    if (!en_i) begin
      rel_d = 1'b0;
      ack_d = 1'b0;
    end else begin
      if (addr_evt_i)  rel_d = 1'b0;
      if (evt.rel_set) rel_d = 1'b1;
      if (evt.ack_upd) ack_d = ack_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_load_q <= 1'b0;
      stop_q    <= 1'b0;
      rel_q     <= 1'b0;
      ack_q     <= 1'b0;
    end else begin
      sh_load_q <= evt.load;
      stop_q    <= evt.stop;
      rel_q     <= rel_d;
      ack_q     <= ack_d;
    end
  end

  assign load_o     = evt.load;
  assign sh_load_o  = sh_load_q;
  assign stop_req_o = stop_q;
  assign sda_rel_o  = rel_q;
  assign rx_ack_o   = ack_q;

  // R5
  stop_on_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && is_master_i && !rw_i && byte_done_i && ack_i) |=> (stop_req_o && !sh_load_o));
  // R5
  load_stop_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sh_load_o, stop_req_o}));
  // R6
  rel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_rel_o && en_i && !addr_evt_i) |=> sda_rel_o);
  // R8
  no_load_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending_i) |=> !sh_load_o);
endmodule

// File: rtl/i2c_txb_rx.sv
module i2c_txb_rx #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (!en_i)     q_d = '0;
    else if (ld_i) q_d = din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R1
  rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (q_o == '0));
  // R9
  rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && ld_i) |=> (q_o == $past(din_i)));
endmodule

// File: rtl/i2c_txb_handoff.sv
module i2c_txb_handoff #(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable_i,
  input  logic              is_master_i,
  input  logic              rw_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              addr_evt_i,
  input  logic              byte_done_i,
  input  logic              ack_i,
  input  logic              rx_load_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  output logic              sh_load_o,
  output logic [DATA_W-1:0] sh_data_o,
  output logic              txbe_o,
  output logic              rx_ack_o,
  output logic              stop_req_o,
  output logic              sda_release_o,
  output logic [DATA_W-1:0] rx_data_o
);
  localparam int SYNC_MSB = SYNC_STAGES - 1;

  logic [SYNC_MSB:0] rst_sync_q;
  logic              rst_int_n;
  logic              load_w;
  logic              empty_w;

  // Assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_MSB-1:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_MSB];

  i2c_txb_hold #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .en_i      (enable_i),
    .wr_i      (wr_i),
    .wdata_i   (wr_data_i),
    .load_i    (load_w),
    .empty_o   (empty_w),
    .sh_data_o (sh_data_o)
  );

  i2c_txb_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .en_i        (enable_i),
    .is_master_i (is_master_i),
    .rw_i        (rw_i),
    .addr_evt_i  (addr_evt_i),
    .byte_done_i (byte_done_i),
    .ack_i       (ack_i),
    .pending_i   (!empty_w),
    .load_o      (load_w),
    .sh_load_o   (sh_load_o),
    .stop_req_o  (stop_req_o),
    .sda_rel_o   (sda_release_o),
    .rx_ack_o    (rx_ack_o)
  );

  i2c_txb_rx #(.DATA_W(DATA_W)) u_rx (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en_i  (enable_i),
    .ld_i  (rx_load_i),
    .din_i (rx_byte_i),
    .q_o   (rx_data_o)
  );

  assign txbe_o = empty_w;

  // R10
  wr_with_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (enable_i && wr_i && load_w) |=> (sh_load_o && !txbe_o));
endmodule

// File: tb/i2c_txb_handoff_bench.sv
module i2c_txb_handoff_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable_i = 1'b0, is_master_i = 1'b0, rw_i = 1'b0;
  logic       wr_i = 1'b0, addr_evt_i = 1'b0, byte_done_i = 1'b0, ack_i = 1'b0;
  logic       rx_load_i = 1'b0;
  logic [7:0] wr_data_i = '0, rx_byte_i = '0;
  logic       sh_load_o, txbe_o, rx_ack_o, stop_req_o, sda_release_o;
  logic [7:0] sh_data_o, rx_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  i2c_txb_handoff u_i2c_txb_handoff (.*);

  // Behavioural reference model
  bit       m_empty = 1, m_load = 0, m_stop = 0, m_rel = 0, m_ack = 0;
  bit [7:0] m_hold = 0, m_sh = 0, m_rx = 0;

  always @(posedge clk or negedge rst_n) begin
    bit tx, fire, nack;
    if (!rst_n || !enable_i) begin
      m_empty <= 1; m_load <= 0; m_stop <= 0; m_rel <= 0; m_ack <= 0;
      m_hold <= 0; m_sh <= 0; m_rx <= 0;
    end else begin
      tx = (is_master_i && rw_i == 0) || (!is_master_i && rw_i == 1);
      fire = 0; nack = 0;
      if (is_master_i) begin
        if (addr_evt_i || (byte_done_i && tx)) begin
          m_ack <= ack_i;
          if (ack_i) nack = 1;
          else if (tx && !m_empty) fire = 1;
        end
      end else begin
        if (addr_evt_i) m_rel <= 0;
        if (addr_evt_i && tx && !m_empty) fire = 1;
        if (byte_done_i && tx) begin
          m_ack <= ack_i;
          if (ack_i) m_rel <= 1;
          else if (!m_empty) fire = 1;
        end
      end
      m_load <= fire;
      m_stop <= nack;
      if (fire) begin m_sh <= m_hold; m_empty <= 1; end
      if (wr_i) begin m_hold <= wr_data_i; m_empty <= 0; end
      if (rx_load_i) m_rx <= rx_byte_i;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      chk("R2 txbe model",      txbe_o,        m_empty);
      chk("R3 load model",      sh_load_o,     m_load);
      chk("R4 data model",      sh_data_o,     m_sh);
      chk("R5 stop model",      stop_req_o,    m_stop);
      chk("R6 release model",   sda_release_o, m_rel);
      chk("R7 ack model",       rx_ack_o,      m_ack);
      chk("R9 rx model",        rx_data_o,     m_rx);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  // one strobe cycle, then pulses drop; outputs checked right after
  task automatic cyc(input bit wr, input bit [7:0] wd, input bit ae, input bit bd, input bit ak);
    @(negedge clk);
    wr_i = wr; wr_data_i = wd; addr_evt_i = ae; byte_done_i = bd; ack_i = ak;
    @(negedge clk);
    wr_i = 0; addr_evt_i = 0; byte_done_i = 0; ack_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk("R1 txbe", txbe_o, 1); chk("R1 load", sh_load_o, 0); chk("R1 rx", rx_data_o, 0);
    enable_i = 1; is_master_i = 1; rw_i = 0;
    cyc(1, 8'hA5, 0, 0, 0);
    chk("R2 txbe cleared", txbe_o, 0);
    cyc(0, 0, 1, 0, 0);
    chk("R3 load pulse", sh_load_o, 1); chk("R3 byte", sh_data_o, 8'hA5); chk("R3 txbe", txbe_o, 1);
    @(negedge clk); chk("R3 pulse ends", sh_load_o, 0);
    cyc(1, 8'h3C, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R4 load", sh_load_o, 1); chk("R4 byte", sh_data_o, 8'h3C);
    cyc(1, 8'h77, 0, 0, 0);
    cyc(0, 0, 0, 1, 1);
    chk("R5 stop", stop_req_o, 1); chk("R5 no load", sh_load_o, 0); chk("R5 txbe", txbe_o, 0);
    chk("R7 ack bit", rx_ack_o, 1);
    @(negedge clk); chk("R5 stop pulse ends", stop_req_o, 0);
    rw_i = 1;
    cyc(0, 0, 0, 1, 0);
    chk("R8 receiver no load", sh_load_o, 0); chk("R8 txbe", txbe_o, 0);
    chk("R7 ack held", rx_ack_o, 1);
    is_master_i = 0; rw_i = 1;
    cyc(0, 0, 1, 0, 1);
    chk("R6 slave addr load", sh_load_o, 1); chk("R6 byte", sh_data_o, 8'h77);
    cyc(1, 8'h12, 0, 0, 0);
    cyc(0, 0, 0, 1, 1);
    chk("R6 release", sda_release_o, 1); chk("R6 no load", sh_load_o, 0); chk("R6 txbe", txbe_o, 0);
    repeat (3) @(negedge clk);
    chk("R6 release held", sda_release_o, 1);
    cyc(0, 0, 1, 0, 0);
    chk("R6 recall load", sh_load_o, 1); chk("R6 recall byte", sh_data_o, 8'h12);
    chk("R6 release drop", sda_release_o, 0);
    cyc(1, 8'h99, 0, 0, 0);
    cyc(1, 8'h55, 0, 1, 0);
    chk("R10 old byte", sh_data_o, 8'h99); chk("R10 load", sh_load_o, 1); chk("R10 txbe", txbe_o, 0);
    cyc(0, 0, 0, 1, 0);
    chk("R10 new byte", sh_data_o, 8'h55);
    @(negedge clk);
    rx_load_i = 1; rx_byte_i = 8'hC3;
    @(negedge clk); rx_load_i = 0;
    chk("R9 rx byte", rx_data_o, 8'hC3);
    enable_i = 0;
    @(negedge clk);
    chk("R1 disable txbe", txbe_o, 1); chk("R1 disable rx", rx_data_o, 0);
    chk("R1 disable data", sh_data_o, 0);
    enable_i = 1; is_master_i = 1; rw_i = 0;
    cyc(0, 0, 1, 0, 0);
    chk("R8 empty no load", sh_load_o, 0); chk("R7 ack zero", rx_ack_o, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule